// File: doc/BRIEF.md
# Configuration Register Override Sequencer

This block drives the side-band and register bus of a link controller's configuration reconfiguration port. On a start request it runs one fixed sequence. It holds the port's reset and the core power-on reset low. It waits out a settling period computed from the clock period. It pulses a shift-load strobe while an interface-select line stays high, and then hands the bus over by dropping interface-select. Two four-cycle writes follow: the first enables override mode and the second places a new 16-bit identifier in the identifier register. A single read then fetches the identifier back, and the sampled readback is compared with the value that was written.

At the end of the sequence the core power-on reset is released, a one-cycle done pulse is given, and a sticky mismatch flag reports whether the readback differed from the written identifier. The identifier is captured when the start request is accepted. A start request that arrives while a sequence is in progress does nothing.

Top module: `ovr_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to idle. Idle outputs are: `busy`=0, `done`=0, `mismatch`=0, `bus_wr`=0, `bus_rd`=0, `bus_addr`=0, `bus_wdata`=0, `rcfg_rst_n`=1, `core_por_n`=1, `shift_ld`=1, `if_sel`=1.
- R2: A `start` sampled high while idle begins the sequence in the next cycle. For RST_CYC cycles (8 by default), `rcfg_rst_n` and `core_por_n` are 0 and `shift_ld` and `if_sel` are 1.
- R3: After the reset phase, `rcfg_rst_n` returns to 1 while `shift_ld` and `if_sel` stay 1. This settling phase lasts ceil(SETTLE_NS*1000/CLK_PS) cycles, which is 81 at 324 ns and 4000 ps.
- R4: `shift_ld` then goes low for exactly LOAD_CYC (4) cycles and then high for SEL_GAP (4) cycles, with `if_sel` at 1 throughout. After that, `if_sel` is 0 until the sequence ends.
- R5: Next, `bus_wr` is 1 for WR_HOLD (4) cycles with `bus_addr`=0 and `bus_wdata`=0. This is the write that enables override mode.
- R6: Directly after that write, `bus_wr` is 1 for another 4 cycles with `bus_addr`=0x009 and `bus_wdata` equal to the identifier.
- R7: Next, `bus_rd` is 1 for one cycle with `bus_addr`=0x009. `bus_rdata` is sampled at the end of the cycle RD_LAT (4) cycles after that read cycle. `bus_addr` stays 0x009 until the sample is taken.
- R8: `core_por_n` stays 0 from the first reset-phase cycle through the sample cycle, so its low time is never shorter than max(10 cycles, 20 ns). In the following cycle, `done` is 1 for exactly one cycle and `core_por_n` returns to 1.
- R9: `mismatch` is set to 1 in the done cycle if the sampled readback differs from the identifier. It then holds through idle until the next accepted start or a reset clears it. A matching readback leaves it at 0.
- R10: `start` has no effect while `busy` is 1 or in the done cycle. `busy` is 1 from the first reset-phase cycle through the sample cycle.
- R11: In the done cycle, all bus and side-band outputs take their idle values.
- R12: The identifier written in R6 is the value of `new_id` at the edge where start was accepted. Later changes of `new_id` do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to run the sequence |
| new_id | input | 16 | Identifier to write |
| bus_rdata | input | 16 | Read data from the reconfiguration bus |
| rcfg_rst_n | output | 1 | Reconfiguration port reset, active low |
| core_por_n | output | 1 | Core power-on reset, active low |
| shift_ld | output | 1 | Shift-load strobe |
| if_sel | output | 1 | Interface select; low hands the bus to register access |
| bus_wr | output | 1 | Write strobe |
| bus_rd | output | 1 | Read strobe |
| bus_addr | output | 10 | Word address |
| bus_wdata | output | 16 | Write data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| mismatch | output | 1 | Sticky readback mismatch flag |

## Verification
The hardest behaviour to reach is the exact cycle in which the readback is sampled. A bus model that holds one steady value would hide a sampler that is off by one. To expose that, the bench drives the expected value on `bus_rdata` only in the single cycle the requirements name, and drives its complement in every other cycle. The bench also reaches the ignored-start cases: it pulses start in the middle of a run and again exactly in the done cycle, and it changes `new_id` during a run. Any of these would show up as a second sequence or as a wrong write value in the cycle-by-cycle comparison.

// File: rtl/ovr_pkg.sv
package ovr_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_RST, S_SETTLE, S_LOAD, S_GAP, S_WEN, S_WID, S_RD, S_DONE
  } ovr_state_e;

  function automatic int unsigned ceil_div(input int unsigned n, input int unsigned d);
    return (n + d - 1) / d;
  endfunction

  // cycles needed to cover a wait given in ns at a clock period given in ps
  function automatic int unsigned ns_to_cycles(input int unsigned ns, input int unsigned ps);
    return ceil_div(ns * 1000, ps);
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/ovr_timer.sv
module ovr_timer #(
  parameter int unsigned W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         zero
);
  always_ff @(posedge clk) begin
    if (!rst_n)             cnt <= '0;
    else if (load)          cnt <= load_val;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // a loaded count must run down one step per cycle
  p_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !zero) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/ovr_cmp.sv
module ovr_cmp #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          sample,
  input  logic [DW-1:0] got,
  input  logic [DW-1:0] want,
  output logic          mismatch
);
  always_ff @(posedge clk) begin
    if (!rst_n)       mismatch <= 1'b0;
    else if (clr)     mismatch <= 1'b0;
    else if (sample && (got != want)) mismatch <= 1'b1;
  end

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mismatch && !clr) |=> mismatch);
endmodule

// File: rtl/ovr_seq.sv
module ovr_seq
  import ovr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned CLK_PS    = 4000,
  parameter int unsigned SETTLE_NS = 324,
  parameter int unsigned RST_CYC   = 8,
  parameter int unsigned LOAD_CYC  = 4,
  parameter int unsigned SEL_GAP   = 4,
  parameter int unsigned WR_HOLD   = 4,
  parameter int unsigned RD_LAT    = 4,
  parameter int unsigned POR_NS    = 20,
  parameter int unsigned POR_CYC   = 10,
  parameter int unsigned EN_ADDR   = 0,
  parameter int unsigned ID_ADDR   = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] new_id,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              rcfg_rst_n,
  output logic              core_por_n,
  output logic              shift_ld,
  output logic              if_sel,
  output logic              bus_wr,
  output logic              bus_rd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              busy,
  output logic              done,
  output logic              mismatch
);
  localparam int unsigned SETTLE_C = ns_to_cycles(SETTLE_NS, CLK_PS);
  localparam int unsigned POR_C    = max2(POR_CYC, ns_to_cycles(POR_NS, CLK_PS));
  localparam int unsigned RD_C     = RD_LAT + 1;
  localparam int unsigned MAXD     = max2(max2(max2(RST_CYC, SETTLE_C), max2(LOAD_CYC, SEL_GAP)),
                                          max2(WR_HOLD, RD_C));
  localparam int unsigned TW       = cnt_width(MAXD);
  localparam int unsigned SW       = cnt_width(SETTLE_C + 1);
  localparam int unsigned PW       = cnt_width(POR_C + 1);

  function automatic logic [TW-1:0] reload(input ovr_state_e s);
    int unsigned d;
    case (s)
      S_RST:    d = RST_CYC;
      S_SETTLE: d = SETTLE_C;
      S_LOAD:   d = LOAD_CYC;
      S_GAP:    d = SEL_GAP;
      S_WEN:    d = WR_HOLD;
      S_WID:    d = WR_HOLD;
      S_RD:     d = RD_C;
      default:  d = 1;
    endcase
    return TW'(d - 1);
  endfunction

  ovr_state_e        state_q, state_d;
  logic [TW-1:0]     tmr_cnt;
  logic              tmr_zero, tmr_load;
  logic [DATA_W-1:0] id_q;
  logic              accept, rd_issue, rd_sample;

  assign accept = (state_q == S_IDLE) && start;

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE:   if (start)    state_d = S_RST;
      S_RST:    if (tmr_zero) state_d = S_SETTLE;
      S_SETTLE: if (tmr_zero) state_d = S_LOAD;
      S_LOAD:   if (tmr_zero) state_d = S_GAP;
      S_GAP:    if (tmr_zero) state_d = S_WEN;
      S_WEN:    if (tmr_zero) state_d = S_WID;
      S_WID:    if (tmr_zero) state_d = S_RD;
      S_RD:     if (tmr_zero) state_d = S_DONE;
      default:                state_d = S_IDLE;
    endcase
  end

  assign tmr_load = (state_d != state_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      id_q    <= '0;
    end else begin
      state_q <= state_d;
      if (accept) id_q <= new_id;
    end
  end

  ovr_timer #(.W(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(reload(state_d)),
    .cnt(tmr_cnt), .zero(tmr_zero)
  );

  // read is issued in the first cycle of S_RD, sampled in its last
  assign rd_issue  = (state_q == S_RD) && (tmr_cnt == TW'(RD_LAT));
  assign rd_sample = (state_q == S_RD) && tmr_zero;

  ovr_cmp #(.DW(DATA_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .clr(accept), .sample(rd_sample),
    .got(bus_rdata), .want(id_q), .mismatch(mismatch)
  );

  assign rcfg_rst_n = (state_q != S_RST);
  assign core_por_n = (state_q == S_IDLE) || (state_q == S_DONE);
  assign shift_ld   = (state_q != S_LOAD);
  assign if_sel     = !((state_q == S_WEN) || (state_q == S_WID) || (state_q == S_RD));
  assign bus_wr     = (state_q == S_WEN) || (state_q == S_WID);
  assign bus_rd     = rd_issue;
  assign bus_addr   = ((state_q == S_WID) || (state_q == S_RD)) ? ADDR_W'(ID_ADDR) : ADDR_W'(EN_ADDR);
  assign bus_wdata  = (state_q == S_WID) ? id_q : '0;
  assign busy       = (state_q != S_IDLE) && (state_q != S_DONE);
  assign done       = (state_q == S_DONE);

  // ---------------- checking counters and assertions ----------------
  logic [SW-1:0] settle_cnt;
  logic [PW-1:0] por_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !rcfg_rst_n) settle_cnt <= '0;
    else if (busy && shift_ld && if_sel && settle_cnt != SW'(SETTLE_C))
      settle_cnt <= settle_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || core_por_n) por_cnt <= '0;
    else if (por_cnt != PW'(POR_C)) por_cnt <= por_cnt + 1'b1;
  end

  p_idle_after_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (!bus_wr && !bus_rd && !busy && !done && core_por_n && shift_ld && if_sel));

  p_settle_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shift_ld) |-> (settle_cnt == SW'(SETTLE_C)));

  p_load_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_ld |-> (if_sel && rcfg_rst_n && !core_por_n));

  p_bus_owned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr || bus_rd) |-> (!if_sel && shift_ld && !core_por_n && rcfg_rst_n));

  p_wr_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && $past(bus_wr) && bus_addr == $past(bus_addr)) |-> (bus_wdata == $past(bus_wdata)));

  p_por_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_por_n) |-> (por_cnt == PW'(POR_C)));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_no_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> !busy);
endmodule

// File: tb/tb_ovr_seq.sv
module tb_ovr_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] new_id = 16'h0;
  logic [15:0] bus_rdata;
  logic        rcfg_rst_n, core_por_n, shift_ld, if_sel, bus_wr, bus_rd, busy, done, mismatch;
  logic [9:0]  bus_addr;
  logic [15:0] bus_wdata;

  always #2 clk = ~clk; // 250 MHz

  ovr_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .new_id(new_id), .bus_rdata(bus_rdata),
    .rcfg_rst_n(rcfg_rst_n), .core_por_n(core_por_n), .shift_ld(shift_ld), .if_sel(if_sel),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .busy(busy), .done(done), .mismatch(mismatch)
  );

  // phase boundaries restated from the requirements
  localparam int N_SET = (324 * 1000 + 4000 - 1) / 4000;
  localparam int E1 = 8;
  localparam int E2 = E1 + N_SET;
  localparam int E3 = E2 + 4;
  localparam int E4 = E3 + 4;
  localparam int E5 = E4 + 4;
  localparam int E6 = E5 + 4;
  localparam int T_SAMP = E6 + 4;
  localparam int E7 = T_SAMP + 1;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit chk_en = 0;
  bit finished = 0;

  bit        m_run = 0;
  int        m_t = 0;
  logic [15:0] m_id = 16'h0;
  bit        m_mis = 0;
  logic [15:0] rd_val = 16'h0;

  // the expected word appears only in the one cycle it must be sampled
  assign bus_rdata = (m_run && m_t == T_SAMP) ? rd_val : ~rd_val;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run <= 0; m_t <= 0; m_mis <= 0;
    end else if (!m_run) begin
      if (start) begin
        m_run <= 1; m_t <= 0; m_id <= new_id; m_mis <= 0;
      end
    end else begin
      if (m_t == T_SAMP) m_mis <= (rd_val != m_id);
      if (m_t == E7) m_run <= 0;
      else m_t <= m_t + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s t=%0d actual=%h expected=%h", tag, m_t, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en && !finished) begin
      bit rp, sp, lp, gp, wp, ip, dp, rdp;
      rp  = m_run && m_t < E1;
      sp  = m_run && m_t >= E1 && m_t < E2;
      lp  = m_run && m_t >= E2 && m_t < E3;
      gp  = m_run && m_t >= E3 && m_t < E4;
      wp  = m_run && m_t >= E4 && m_t < E5;
      ip  = m_run && m_t >= E5 && m_t < E6;
      rdp = m_run && m_t >= E6 && m_t < E7;
      dp  = m_run && m_t == E7;
      if (!m_run) begin
        chk("R1 idle rcfg_rst_n", 32'(rcfg_rst_n), 1);
        chk("R1 idle core_por_n", 32'(core_por_n), 1);
        chk("R1 idle shift_ld", 32'(shift_ld), 1);
        chk("R1 idle if_sel", 32'(if_sel), 1);
        chk("R1 idle bus_wr", 32'(bus_wr), 0);
        chk("R1 idle bus_rd", 32'(bus_rd), 0);
        chk("R1 idle bus_addr", 32'(bus_addr), 0);
        chk("R1 idle bus_wdata", 32'(bus_wdata), 0);
        chk("R10 idle busy", 32'(busy), 0);
        chk("R1 idle done", 32'(done), 0);
        chk("R9 idle mismatch", 32'(mismatch), 32'(m_mis));
      end else begin
        chk("R2 rcfg_rst_n", 32'(rcfg_rst_n), 32'(!rp));
        chk("R8 core_por_n", 32'(core_por_n), 32'(dp));
        chk("R3/R4 shift_ld", 32'(shift_ld), 32'(!lp));
        chk("R4 if_sel", 32'(if_sel), 32'(!(wp || ip || rdp)));
        chk("R5/R6 bus_wr", 32'(bus_wr), 32'(wp || ip));
        chk("R7 bus_rd", 32'(bus_rd), 32'(m_t == E6));
        chk("R6/R7 bus_addr", 32'(bus_addr), (ip || rdp) ? 32'h9 : 32'h0);
        chk("R6/R12 bus_wdata", 32'(bus_wdata), ip ? 32'(m_id) : 32'h0);
        chk("R10 busy", 32'(busy), 32'(!dp));
        chk("R8/R11 done", 32'(done), 32'(dp));
        chk("R9 mismatch", 32'(mismatch), 32'(m_mis));
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      bad++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic pulse_start();
    start = 1; tick(); start = 0;
  endtask

  task automatic wait_end();
    do tick(); while (m_run);
  endtask

  task automatic wait_t(input int t);
    while (!(m_run && m_t == t)) tick();
  endtask

  initial begin
    tick(); chk_en = 1;
    tick(); tick(); rst_n = 1;            // R1 reset state observed
    repeat (3) tick();

    // matching readback
    new_id = 16'hB500; rd_val = 16'hB500;
    pulse_start();
    wait_end();
    repeat (3) tick();

    // mismatch, start while busy (R10), id change mid-run (R12)
    new_id = 16'hABCD; rd_val = 16'h1234;
    pulse_start();
    wait_t(20); new_id = 16'h5555; pulse_start();
    wait_t(E5 + 1); pulse_start();
    wait_end();
    repeat (5) tick();                    // R9 sticky in idle

    // R9 clear on start; start in the done cycle ignored (R10)
    rd_val = 16'h5555;
    pulse_start();
    wait_t(E7); pulse_start();
    repeat (4) tick();

    // reset mid-sequence (R1), then a final run
    new_id = 16'h0001; rd_val = 16'h0001;
    pulse_start();
    wait_t(50); rst_n = 0; tick(); tick(); rst_n = 1;
    repeat (3) tick();
    pulse_start();
    wait_end();
    repeat (3) tick();
    summary();
  end
endmodule